// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a byte-wide configuration front end reached through two I/O addresses. Address 0 is the index port and address 1 is the data port. After reset the port is locked. Data-port reads return all ones and data-port writes are dropped. The port opens only when a fixed four-byte key is written to the index port. While open, an index write picks a configuration register, and data-port accesses read or write that register. A command written to a global register closes the port again.

Registers below index 0x30 are global: a logical-device selector, a read-only chip identifier and a revision. Registers from 0x30 up belong to the bank of the device that the selector names. Each bank keeps an activate bit and a 16-bit base address inside this block and drives both out as outputs. Every other bank register is passed through to the selected attached device over a simple strobe interface. The read data from that device comes back through the data port.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is locked, the device selector is 0, the index is 0, every activate bit and base address is 0, and `rdata_o` is 0xFF.
- R2: While locked, a data-port read returns 0xFF and a data-port write changes no register and raises no device strobe.
- R3: The port unlocks only after the index port receives 0x87, 0x01, 0x55, 0x55 in that order. Index-port writes made while locked do not change the index.
- R4: A byte that breaks the key sequence resets the matcher, except that 0x87 restarts it as the first key byte.
- R5: A data write of 0x02 to global register 0x02 locks the port. Any other value written there leaves it unlocked.
- R6: Global register 0x07 holds an 8-bit device selector that can be read and written.
- R7: Registers 0x20 and 0x21 read the high and low bytes of the chip identifier. The low nibble of 0x22 reads the revision and its high nibble reads 0. Writes to these three registers are ignored, and any other undefined global register reads 0x00.
- R8: In each bank, bit 0 of register 0x30 drives that device's bit of `dev_active_o`, and bits 7:1 read back as 0.
- R9: In each bank, registers 0x60 and 0x61 hold the high and low bytes of that device's 16-bit base address, which `dev_base_o[16*d +: 16]` shows.
- R10: A data access to any other bank register (index ≥ 0x30) raises exactly one `dev_sel_o` bit, the one for the selected device, together with `dev_wr_o` or `dev_rd_o`. It also presents the index and write data, and a read returns that device's `dev_rdata_i` byte.
- R11: When the selector names no attached device (≥ NUM_DEV), bank writes are ignored, bank reads return 0xFF and no device strobe is raised.
- R12: A read of the index port returns the current index while unlocked and 0xFF while locked. The result of any port read appears on `rdata_o` after the next clock edge and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Port write strobe |
| rd_i | input | 1 | Port read strobe |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| dev_sel_o | output | NUM_DEV | One-hot target of a forwarded bank access |
| dev_wr_o | output | 1 | Forwarded bank write strobe |
| dev_rd_o | output | 1 | Forwarded bank read strobe |
| dev_idx_o | output | 8 | Register index of the forwarded access |
| dev_wdata_o | output | 8 | Write data of the forwarded access |
| dev_rdata_i | input | 8*NUM_DEV | Read data from each attached device |
| dev_active_o | output | NUM_DEV | Activate bit of each device |
| dev_base_o | output | 16*NUM_DEV | Base address of each device |

## Verification
The cases hardest to reach from the ports are the partial key matches. One is a broken sequence that must restart on 0x87 rather than fall back to idle. Another is a write that lands on the data port while the port is locked. The stimulus replays every key prefix and several interrupted sequences, checking the lock state after each by reading the index port. It also sets a known selector and index before locking, then writes through the closed port and reopens it to confirm that nothing changed. The bench then sweeps every attached device and an out-of-range selector.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;

  localparam int unsigned KEY_LEN = 4;
  localparam int unsigned STEP_W  = 2;
  localparam logic [STEP_W-1:0] KEY_LAST = STEP_W'(KEY_LEN - 1);

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_CMD    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] BANK_START  = 8'h30;
  localparam logic [7:0] REG_ACT     = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;

  // key byte expected at a given step of the unlock sequence
  function automatic logic [7:0] key_byte(input logic [STEP_W-1:0] pos);
    case (pos)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import cfg_key_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exit_i,
  output logic       unlocked_o
);

  logic [STEP_W-1:0] step_q;
  logic              unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= '0;
      unlocked_q <= 1'b0;
    end else if (unlocked_q) begin
      if (exit_i) begin
        unlocked_q <= 1'b0;
        step_q     <= '0;
      end
    end else if (idx_wr_i) begin
      if (wdata_i == key_byte(step_q)) begin
        if (step_q == KEY_LAST) begin
          unlocked_q <= 1'b1;
          step_q     <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (wdata_i == key_byte('0)) begin
        step_q <= STEP_W'(1);
      end else begin
        step_q <= '0;
      end
    end
  end

  assign unlocked_o = unlocked_q;

endmodule

// File: rtl/cfg_key_global.sv
module cfg_key_global
  import cfg_key_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8712,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ldn_o,
  output logic       exit_o,
  output logic [7:0] rdata_o
);

  logic [7:0] ldn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q <= '0;
    end else if (wr_i && idx_i == REG_LDN) begin
      ldn_q <= wdata_i;
    end
  end

  assign exit_o = wr_i && idx_i == REG_EXIT && wdata_i == EXIT_CMD;
  assign ldn_o  = ldn_q;

  always_comb begin
    case (idx_i)
      REG_LDN:   rdata_o = ldn_q;
      REG_ID_HI: rdata_o = CHIP_ID[15:8];
      REG_ID_LO: rdata_o = CHIP_ID[7:0];
      REG_REV:   rdata_o = {4'h0, CHIP_REV};
      default:   rdata_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/cfg_key_bank.sv
module cfg_key_bank
  import cfg_key_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4,
  localparam int unsigned DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [DEV_W-1:0]      dev_i,
  input  logic [7:0]            idx_i,
  input  logic [7:0]            wdata_i,
  output logic                  hit_o,
  output logic [7:0]            rdata_o,
  output logic [NUM_DEV-1:0]    active_o,
  output logic [16*NUM_DEV-1:0] base_o
);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic        act_q;
    logic [15:0] base_q;
    logic        sel;

    assign sel = wr_i && (dev_i == DEV_W'(d));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= 1'b0;
        base_q <= '0;
      end else if (sel) begin
        case (idx_i)
          REG_ACT:     act_q        <= wdata_i[0];
          REG_BASE_HI: base_q[15:8] <= wdata_i;
          REG_BASE_LO: base_q[7:0]  <= wdata_i;
          default: ;
        endcase
      end
    end

    assign active_o[d]        = act_q;
    assign base_o[16*d +: 16] = base_q;
  end

  assign hit_o = (idx_i == REG_ACT) || (idx_i == REG_BASE_HI) ||
                 (idx_i == REG_BASE_LO);

  always_comb begin
    rdata_o = IDLE_BYTE;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (dev_i == DEV_W'(d)) begin
        case (idx_i)
          REG_ACT:     rdata_o = {7'b0, active_o[d]};
          REG_BASE_HI: rdata_o = base_o[16*d+8 +: 8];
          REG_BASE_LO: rdata_o = base_o[16*d +: 8];
          default:     rdata_o = IDLE_BYTE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
  import cfg_key_pkg::*;
#(
  parameter int unsigned NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h8712,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic                  addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_DEV-1:0]    dev_sel_o,
  output logic                  dev_wr_o,
  output logic                  dev_rd_o,
  output logic [7:0]            dev_idx_o,
  output logic [7:0]            dev_wdata_o,
  input  logic [8*NUM_DEV-1:0]  dev_rdata_i,
  output logic [NUM_DEV-1:0]    dev_active_o,
  output logic [16*NUM_DEV-1:0] dev_base_o
);

  localparam int unsigned DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

  logic       unlocked;
  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic       ldn_valid;
  logic       is_bank;
  logic       bank_hit;
  logic       exit_cmd;
  logic       data_wr;
  logic       data_rd;
  logic       fwd_acc;
  logic [7:0] glob_rdata;
  logic [7:0] bank_rdata;
  logic [7:0] fwd_rdata;
  logic [7:0] rd_val;
  logic [7:0] rdata_q;

  assign data_wr   = unlocked && wr_i && addr_i;
  assign data_rd   = unlocked && rd_i && !wr_i && addr_i;
  assign is_bank   = idx_q >= BANK_START;
  assign ldn_valid = ldn_q < NUM_DEV_B;

  cfg_key_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (wr_i && !addr_i),
    .wdata_i    (wdata_i),
    .exit_i     (exit_cmd),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (unlocked && wr_i && !addr_i) begin
      idx_q <= wdata_i;
    end
  end

  cfg_key_global #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_global (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (data_wr && !is_bank),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .ldn_o   (ldn_q),
    .exit_o  (exit_cmd),
    .rdata_o (glob_rdata)
  );

  cfg_key_bank #(
    .NUM_DEV (NUM_DEV)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (data_wr && is_bank && ldn_valid),
    .dev_i    (ldn_q[DEV_W-1:0]),
    .idx_i    (idx_q),
    .wdata_i  (wdata_i),
    .hit_o    (bank_hit),
    .rdata_o  (bank_rdata),
    .active_o (dev_active_o),
    .base_o   (dev_base_o)
  );

  // pass-through of bank registers not held locally
  assign fwd_acc     = (data_wr || data_rd) && is_bank && !bank_hit && ldn_valid;
  assign dev_wr_o    = fwd_acc && data_wr;
  assign dev_rd_o    = fwd_acc && data_rd;
  assign dev_idx_o   = idx_q;
  assign dev_wdata_o = wdata_i;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
    assign dev_sel_o[d] = fwd_acc && (ldn_q == 8'(d));
  end

  always_comb begin
    fwd_rdata = IDLE_BYTE;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (ldn_q == 8'(d)) fwd_rdata = dev_rdata_i[8*d +: 8];
    end
  end

  always_comb begin
    if (!unlocked)      rd_val = IDLE_BYTE;
    else if (!addr_i)   rd_val = idx_q;
    else if (!is_bank)  rd_val = glob_rdata;
    else if (!ldn_valid) rd_val = IDLE_BYTE;
    else if (bank_hit)  rd_val = bank_rdata;
    else                rd_val = fwd_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= IDLE_BYTE;
    end else if (rd_i && !wr_i) begin
      rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/cfg_key_port_chk.sv
module cfg_key_port_chk #(
  parameter int unsigned NUM_DEV = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               rd_i,
  input logic               addr_i,
  input logic [7:0]         rdata_o,
  input logic [NUM_DEV-1:0] dev_sel_o,
  input logic               dev_wr_o,
  input logic               dev_rd_o,
  input logic [NUM_DEV-1:0] dev_active_o,
  input logic               unlocked,
  input logic               ldn_valid
);

  assert_locked_no_fwd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |-> !dev_wr_o && !dev_rd_o);

  assert_locked_rd_ff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && rd_i && !wr_i && addr_i) |=> rdata_o == 8'hFF);

  assert_locked_act_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(dev_active_o));

  assert_sel_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_sel_o));

  assert_fwd_has_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o || dev_rd_o) |-> $countones(dev_sel_o) == 1);

  assert_bad_dev_no_fwd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldn_valid |-> !dev_wr_o && !dev_rd_o && dev_sel_o == '0);

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

endmodule

bind cfg_key_port cfg_key_port_chk #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .dev_sel_o    (dev_sel_o),
  .dev_wr_o     (dev_wr_o),
  .dev_rd_o     (dev_rd_o),
  .dev_active_o (dev_active_o),
  .unlocked     (unlocked),
  .ldn_valid    (ldn_valid)
);

// File: tb/cfg_key_port_tb_top.sv
module cfg_key_port_tb_top;

  localparam int ND = 4;
  localparam logic [15:0] ID  = 16'h8712;
  localparam logic [3:0]  REV = 4'h3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_i = 1'b0;
  logic            rd_i = 1'b0;
  logic            addr_i = 1'b0;
  logic [7:0]      wdata_i = '0;
  logic [7:0]      rdata_o;
  logic [ND-1:0]   dev_sel_o;
  logic            dev_wr_o;
  logic            dev_rd_o;
  logic [7:0]      dev_idx_o;
  logic [7:0]      dev_wdata_o;
  logic [8*ND-1:0] dev_rdata_i;
  logic [ND-1:0]   dev_active_o;
  logic [16*ND-1:0] dev_base_o;

  int checks = 0;
  int errors = 0;
  int fwd_wr_cnt = 0;
  logic [ND-1:0] cap_sel;
  logic [7:0] cap_idx, cap_data;

  always #2 clk_i = ~clk_i;

  // attached device model: reply depends on device number and index
  for (genvar d = 0; d < ND; d++) begin : g_devm
    assign dev_rdata_i[8*d +: 8] = {4'(d), 4'h5} ^ dev_idx_o;
  end

  always @(posedge clk_i) begin
    if (dev_wr_o) begin
      fwd_wr_cnt <= fwd_wr_cnt + 1;
      cap_sel    <= dev_sel_o;
      cap_idx    <= dev_idx_o;
      cap_data   <= dev_wdata_o;
    end
  end

  cfg_key_port #(.NUM_DEV(ND), .CHIP_ID(ID), .CHIP_REV(REV)) dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic a, logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic a, output logic [7:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic unlock();
    bus_wr(0, 8'h87); bus_wr(0, 8'h01); bus_wr(0, 8'h55); bus_wr(0, 8'h55);
  endtask

  task automatic relock();
    bus_wr(0, 8'h02); bus_wr(1, 8'h02);
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    bus_wr(0, idx); bus_wr(1, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, output logic [7:0] d);
    bus_wr(0, idx); bus_rd(1, d);
  endtask

  task automatic is_open(output logic o);
    logic [7:0] v;
    bus_wr(0, 8'h3C);
    bus_rd(0, v);
    o = (v == 8'h3C);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic o;
    logic [7:0] keys [4];
    keys[0] = 8'h87; keys[1] = 8'h01; keys[2] = 8'h55; keys[3] = 8'h55;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 rdata", 64'(rdata_o), 64'hFF);
    check("R1 active", 64'(dev_active_o), 0);
    check("R1 base", dev_base_o, 0);
    bus_rd(1, v);
    check("R2 locked data read", 64'(v), 64'hFF);
    bus_rd(0, v);
    check("R12 locked index read", 64'(v), 64'hFF);

    // R3 every proper prefix keeps the port locked
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < n; k++) bus_wr(0, keys[k]);
      bus_wr(0, 8'h00);
      bus_rd(0, v);
      check("R3 prefix stays locked", 64'(v), 64'hFF);
    end
    unlock();
    bus_rd(0, v);
    check("R3 unlock index preserved at 0", 64'(v), 64'h00);
    reg_rd(8'h07, v);
    check("R1 ldn reset", 64'(v), 0);
    reg_rd(8'h30, v);
    check("R1 dev0 active reset", 64'(v), 0);

    // R5 wrong exit value keeps port open, correct one locks
    reg_wr(8'h02, 8'h01);
    is_open(o);
    check("R5 other value stays open", 64'(o), 1);
    relock();
    bus_rd(0, v);
    check("R5 exit locks", 64'(v), 64'hFF);

    // R4 restart on 0x87 and reset on other bytes
    bus_wr(0, 8'h87); bus_wr(0, 8'h01); bus_wr(0, 8'h87);
    bus_wr(0, 8'h01); bus_wr(0, 8'h55); bus_wr(0, 8'h55);
    is_open(o);
    check("R4 restart mid sequence", 64'(o), 1);
    relock();
    bus_wr(0, 8'h87); bus_wr(0, 8'h87); bus_wr(0, 8'h01);
    bus_wr(0, 8'h55); bus_wr(0, 8'h55);
    is_open(o);
    check("R4 repeated first byte", 64'(o), 1);
    relock();
    bus_wr(0, 8'h87); bus_wr(0, 8'h01); bus_wr(0, 8'h55);
    bus_wr(0, 8'h00); bus_wr(0, 8'h55);
    bus_rd(0, v);
    check("R4 broken sequence locked", 64'(v), 64'hFF);
    bus_wr(0, 8'h01); bus_wr(0, 8'h55); bus_wr(0, 8'h55);
    bus_rd(0, v);
    check("R4 no stale progress", 64'(v), 64'hFF);

    // R6 selector sweep
    unlock();
    for (int i = 0; i < 256; i += 17) begin
      reg_wr(8'h07, 8'(i));
      reg_rd(8'h07, v);
      check("R6 selector readback", 64'(v), 64'(i));
    end

    // R7 identity registers, read-only
    reg_rd(8'h20, v); check("R7 id high", 64'(v), 64'(ID[15:8]));
    reg_rd(8'h21, v); check("R7 id low", 64'(v), 64'(ID[7:0]));
    reg_rd(8'h22, v); check("R7 revision", 64'(v), 64'({4'h0, REV}));
    reg_wr(8'h20, 8'h00); reg_wr(8'h21, 8'h00); reg_wr(8'h22, 8'hFF);
    reg_rd(8'h20, v); check("R7 id high after write", 64'(v), 64'(ID[15:8]));
    reg_rd(8'h22, v); check("R7 revision after write", 64'(v), 64'({4'h0, REV}));
    reg_rd(8'h11, v); check("R7 undefined global", 64'(v), 0);

    // R8 R9 per-device registers
    for (int d = 0; d < ND; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_wr(8'h30, 8'hF0 | 8'(d & 1));
      reg_wr(8'h60, 8'h10 + 8'(d));
      reg_wr(8'h61, 8'hA0 + 8'(3 * d));
    end
    for (int d = 0; d < ND; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_rd(8'h30, v); check("R8 active readback", 64'(v), 64'(d & 1));
      reg_rd(8'h60, v); check("R9 base high", 64'(v), 64'(8'h10 + 8'(d)));
      reg_rd(8'h61, v); check("R9 base low", 64'(v), 64'(8'hA0 + 8'(3 * d)));
      check("R9 base port", 64'(dev_base_o[16*d +: 16]),
            64'({8'h10 + 8'(d), 8'hA0 + 8'(3 * d)}));
    end
    check("R8 active port", 64'(dev_active_o), 64'(4'b1010));

    // R10 forwarding
    for (int d = 0; d < ND; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_wr(8'hF0 + 8'(d), 8'h5A ^ 8'(d));
      check("R10 fwd sel", 64'(cap_sel), 64'(1 << d));
      check("R10 fwd idx", 64'(cap_idx), 64'(8'hF0 + 8'(d)));
      check("R10 fwd data", 64'(cap_data), 64'(8'h5A ^ 8'(d)));
      reg_rd(8'h45, v);
      check("R10 fwd read", 64'(v), 64'({4'(d), 4'h5} ^ 8'h45));
    end
    check("R10 fwd write count", 64'(fwd_wr_cnt), ND);

    // R11 selector with no device
    reg_wr(8'h07, 8'(ND + 1));
    reg_wr(8'h30, 8'h01);
    reg_wr(8'h60, 8'hEE);
    reg_wr(8'h50, 8'h77);
    check("R11 active unchanged", 64'(dev_active_o), 64'(4'b1010));
    check("R11 no forward", 64'(fwd_wr_cnt), ND);
    reg_rd(8'h30, v); check("R11 bank read", 64'(v), 64'hFF);
    reg_rd(8'h50, v); check("R11 fwd read", 64'(v), 64'hFF);
    check("R11 base unchanged", 64'(dev_base_o[16 +: 16]), 64'h11A3);

    // R2 writes while locked change nothing
    reg_wr(8'h07, 8'd0);
    bus_wr(0, 8'h30);
    relock();
    bus_wr(0, 8'h30);
    bus_wr(1, 8'h01);
    check("R2 active after locked write", 64'(dev_active_o), 64'(4'b1010));
    unlock();
    bus_rd(0, v);
    check("R3 index kept across lock", 64'(v), 64'h02);
    reg_rd(8'h07, v); check("R2 selector intact", 64'(v), 0);
    reg_rd(8'h30, v); check("R2 dev0 active intact", 64'(v), 0);
    check("R2 no forward while locked", 64'(fwd_wr_cnt), ND);

    // R12 hold between reads
    bus_wr(0, 8'h21);
    bus_rd(1, v);
    repeat (4) @(negedge clk_i);
    check("R12 rdata held", 64'(rdata_o), 64'(ID[7:0]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule